// File: doc/BRIEF.md
# Hardware Pointer Overlay

This block lays one 16x16 pointer image over a raster video stream. A timing generator supplies the horizontal and vertical pixel counters and the two blanking flags, and the block receives the background colour of each pixel alongside them. It returns the merged colour one clock later. Each image pixel is 4 bits wide. The top bit marks the pixel as opaque. The three lower bits turn the red, green and blue channels fully on or off. This gives eight solid colours plus a transparent code.

The block keeps only one image row. At the first cycle of each horizontal blanking interval it works out whether the next scanline crosses the pointer. If it does, it requests that row from memory as four 16-bit words through a request/acknowledge port, while the display is idle. The processor writes the pointer position at any time. The new position is held back until the next vertical blanking interval begins, so a frame is never drawn with two positions.

Top module: `cursor_overlay`

## Requirements
- R1: While `rst` is high, `pix_rgb` is all zeros and `fetch_req` is low.
- R2: `pix_rgb` is registered and reflects the inputs of the previous cycle. In any cycle where `hblank` or `vblank` is high, it equals the previous cycle's `bg_rgb`.
- R3: On the first cycle with `hblank` high, the next line is computed as `vcnt`+1, wrapping to 0 after line `V_TOTAL`-1. If that line lies in rows Y..Y+15 of the committed position, exactly four words are fetched. On every other line, nothing is fetched.
- R4: For image row r, the four word addresses are r*4+0, r*4+1, r*4+2 and r*4+3, issued in that order. `fetch_req` and `fetch_addr` stay unchanged until `fetch_ack`, and each acknowledged cycle loads one word from `fetch_data`.
- R5: `fetch_req` is high only while `hblank` or `vblank` is high, provided each request is acknowledged within the blanking interval.
- R6: The column used is `hcnt` minus the committed X. Word 0 holds columns 0..3, and in each word the most significant nibble is the leftmost pixel.
- R7: For a visible pixel inside the image with bit 3 set, each output channel (red in bits 23:16, green in 15:8, blue in 7:0 at default width) is all ones when its bit is set and all zeros otherwise. Bit 2 drives red, bit 1 green and bit 0 blue.
- R8: For a visible pixel inside the image with bit 3 clear, the output equals the background colour.
- R9: For a visible pixel left of X, at X+16 or beyond, or on a line that was not fetched, the output equals the background colour.
- R10: A write on `pos_we` is stored but only takes effect in the cycle after `vblank` rises. Until then, drawing and fetching use the previously committed position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pos_we | input | 1 | Position write strobe |
| pos_x_in | input | CNT_W | Pointer left column to write |
| pos_y_in | input | CNT_W | Pointer top line to write |
| hcnt | input | CNT_W | Current pixel column |
| vcnt | input | CNT_W | Current scanline |
| hblank | input | 1 | Horizontal blanking flag |
| vblank | input | 1 | Vertical blanking flag |
| bg_rgb | input | 3*COL_W | Background colour, red in the upper field |
| fetch_req | output | 1 | Image word request |
| fetch_addr | output | 6 | Word address: row times four plus word index |
| fetch_ack | input | 1 | Word delivered this cycle |
| fetch_data | input | 16 | Delivered image word |
| pix_rgb | output | 3*COL_W | Merged output colour |

## Verification
The blanking-only request property relies on the memory side answering all four requests before the horizontal blanking interval ends. The stimulus meets this by acknowledging every request on the cycle after it appears, with eight blanking cycles per line. The properties also assume that `vblank` is a level that stays high over whole lines and that a position write never lands on the cycle where `vblank` rises. The stimulus drives the counters as a regular raster and issues writes only in the middle of a frame.

// File: rtl/cursor_pkg.sv
package cursor_pkg;

    localparam int SPR_DIM       = 16;
    localparam int PIX_BITS      = 4;
    localparam int WORD_BITS     = 16;
    localparam int PIX_PER_WORD  = WORD_BITS / PIX_BITS;
    localparam int WORDS_PER_ROW = SPR_DIM / PIX_PER_WORD;
    localparam int ROW_BITS      = SPR_DIM * PIX_BITS;
    localparam int ROW_IDX_W     = $clog2(SPR_DIM);
    localparam int WORD_IDX_W    = $clog2(WORDS_PER_ROW);
    localparam int FETCH_ADDR_W  = ROW_IDX_W + WORD_IDX_W;

    typedef enum logic {
        FETCH_IDLE,
        FETCH_BUSY
    } fetch_state_e;

    typedef struct packed {
        logic opaque;
        logic red;
        logic green;
        logic blue;
    } spr_pix_t;

    typedef logic [ROW_BITS-1:0] row_t;

    // Leftmost pixel sits in the most significant nibble of the row.
    function automatic spr_pix_t pick_pixel(row_t row, logic [ROW_IDX_W-1:0] col);
        return spr_pix_t'(row[ROW_BITS-1-int'(col)*PIX_BITS -: PIX_BITS]);
    endfunction

endpackage

// File: rtl/cursor_pos.sv
module cursor_pos #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pos_we,
    input  logic [CNT_W-1:0] wr_x,
    input  logic [CNT_W-1:0] wr_y,
    input  logic             vblank,
    output logic [CNT_W-1:0] cur_x,
    output logic [CNT_W-1:0] cur_y
);

    logic [CNT_W-1:0] pend_x;
    logic [CNT_W-1:0] pend_y;
    logic             vb_q;
    logic             frame_edge;

    assign frame_edge = vblank && !vb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_x <= '0;
            pend_y <= '0;
            cur_x  <= '0;
            cur_y  <= '0;
            vb_q   <= 1'b0;
        end else begin
            vb_q <= vblank;
            if (pos_we) begin
                pend_x <= wr_x;
                pend_y <= wr_y;
            end
            if (frame_edge) begin
                cur_x <= pend_x;
                cur_y <= pend_y;
            end
        end
    end

endmodule

// File: rtl/cursor_fetch.sv
module cursor_fetch
    import cursor_pkg::*;
#(
    parameter int CNT_W   = 11,
    parameter int V_TOTAL = 525
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    hblank,
    input  logic [CNT_W-1:0]        vcnt,
    input  logic [CNT_W-1:0]        top_y,
    output logic                    fetch_req,
    output logic [FETCH_ADDR_W-1:0] fetch_addr,
    input  logic                    fetch_ack,
    input  logic [WORD_BITS-1:0]    fetch_data,
    output row_t                    row_bits,
    output logic                    row_live
);

    localparam logic [CNT_W-1:0]      LAST_LINE = CNT_W'(V_TOTAL - 1);
    localparam logic [WORD_IDX_W-1:0] LAST_WORD = WORD_IDX_W'(WORDS_PER_ROW - 1);

    fetch_state_e          state;
    logic                  hb_q;
    logic [ROW_IDX_W-1:0]  row_idx;
    logic [WORD_IDX_W-1:0] widx;
    logic [CNT_W-1:0]      next_line;
    logic [CNT_W-1:0]      rel_row;
    logic                  in_rows;
    logic                  line_edge;
    logic                  take_word;

    assign next_line = (vcnt == LAST_LINE) ? '0 : vcnt + 1'b1;
    assign rel_row   = next_line - top_y;
    assign in_rows   = (next_line >= top_y) && (rel_row < CNT_W'(SPR_DIM));
    assign line_edge = hblank && !hb_q;
    assign take_word = (state == FETCH_BUSY) && fetch_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= FETCH_IDLE;
            hb_q     <= 1'b0;
            row_live <= 1'b0;
            row_idx  <= '0;
            widx     <= '0;
        end else begin
            hb_q <= hblank;
            case (state)
                FETCH_IDLE: begin
                    if (line_edge) begin
                        row_live <= in_rows;
                        if (in_rows) begin
                            state   <= FETCH_BUSY;
                            row_idx <= rel_row[ROW_IDX_W-1:0];
                            widx    <= '0;
                        end
                    end
                end
                FETCH_BUSY: begin
                    if (fetch_ack) begin
                        widx <= widx + 1'b1;
                        if (widx == LAST_WORD) begin
                            state <= FETCH_IDLE;
                        end
                    end
                end
                default: state <= FETCH_IDLE;
            endcase
        end
    end

    assign fetch_req  = (state == FETCH_BUSY);
    assign fetch_addr = {row_idx, widx};

    for (genvar i = 0; i < WORDS_PER_ROW; i++) begin : g_word
        logic [WORD_BITS-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (take_word && (widx == WORD_IDX_W'(i))) begin
                word_q <= fetch_data;
            end
        end
        assign row_bits[ROW_BITS-1-i*WORD_BITS -: WORD_BITS] = word_q;
    end

endmodule

// File: rtl/cursor_mix.sv
module cursor_mix
    import cursor_pkg::*;
#(
    parameter int CNT_W = 11,
    parameter int COL_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CNT_W-1:0]   hcnt,
    input  logic               hblank,
    input  logic               vblank,
    input  logic [3*COL_W-1:0] bg_rgb,
    input  logic [CNT_W-1:0]   left_x,
    input  row_t               row_bits,
    input  logic               row_live,
    output logic [3*COL_W-1:0] pix_rgb
);

    logic [CNT_W-1:0]   dx;
    logic               in_box;
    spr_pix_t           px;
    logic [3*COL_W-1:0] spr_rgb;
    logic [3*COL_W-1:0] mix_rgb;

    assign dx     = hcnt - left_x;
    assign in_box = row_live && !hblank && !vblank &&
                    (hcnt >= left_x) && (dx < CNT_W'(SPR_DIM));
    assign px     = pick_pixel(row_bits, dx[ROW_IDX_W-1:0]);
    assign spr_rgb = {{COL_W{px.red}}, {COL_W{px.green}}, {COL_W{px.blue}}};

    always_comb begin
        mix_rgb = bg_rgb;
        if (in_box && px.opaque) begin
            mix_rgb = spr_rgb;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_rgb <= '0;
        end else begin
            pix_rgb <= mix_rgb;
        end
    end

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
    import cursor_pkg::*;
#(
    parameter int CNT_W   = 11,
    parameter int COL_W   = 8,
    parameter int V_TOTAL = 525
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    pos_we,
    input  logic [CNT_W-1:0]        pos_x_in,
    input  logic [CNT_W-1:0]        pos_y_in,
    input  logic [CNT_W-1:0]        hcnt,
    input  logic [CNT_W-1:0]        vcnt,
    input  logic                    hblank,
    input  logic                    vblank,
    input  logic [3*COL_W-1:0]      bg_rgb,
    output logic                    fetch_req,
    output logic [FETCH_ADDR_W-1:0] fetch_addr,
    input  logic                    fetch_ack,
    input  logic [WORD_BITS-1:0]    fetch_data,
    output logic [3*COL_W-1:0]      pix_rgb
);

    logic [CNT_W-1:0] act_x;
    logic [CNT_W-1:0] act_y;
    row_t             row_bits;
    logic             row_live;

    cursor_pos #(.CNT_W(CNT_W)) u_pos (
        .clk    (clk),
        .rst    (rst),
        .pos_we (pos_we),
        .wr_x   (pos_x_in),
        .wr_y   (pos_y_in),
        .vblank (vblank),
        .cur_x  (act_x),
        .cur_y  (act_y)
    );

    cursor_fetch #(.CNT_W(CNT_W), .V_TOTAL(V_TOTAL)) u_fetch (
        .clk        (clk),
        .rst        (rst),
        .hblank     (hblank),
        .vcnt       (vcnt),
        .top_y      (act_y),
        .fetch_req  (fetch_req),
        .fetch_addr (fetch_addr),
        .fetch_ack  (fetch_ack),
        .fetch_data (fetch_data),
        .row_bits   (row_bits),
        .row_live   (row_live)
    );

    cursor_mix #(.CNT_W(CNT_W), .COL_W(COL_W)) u_mix (
        .clk      (clk),
        .rst      (rst),
        .hcnt     (hcnt),
        .hblank   (hblank),
        .vblank   (vblank),
        .bg_rgb   (bg_rgb),
        .left_x   (act_x),
        .row_bits (row_bits),
        .row_live (row_live),
        .pix_rgb  (pix_rgb)
    );

endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk
    import cursor_pkg::*;
#(
    parameter int CNT_W = 11,
    parameter int COL_W = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    hblank,
    input logic                    vblank,
    input logic [3*COL_W-1:0]      bg_rgb,
    input logic [3*COL_W-1:0]      pix_rgb,
    input logic                    fetch_req,
    input logic                    fetch_ack,
    input logic [FETCH_ADDR_W-1:0] fetch_addr,
    input logic [CNT_W-1:0]        act_x,
    input logic [CNT_W-1:0]        act_y
);

    AST_REQ_IN_BLANK: assert property (@(posedge clk) disable iff (rst)
        fetch_req |-> (hblank || vblank)); // R5

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && !fetch_ack) |=> (fetch_req && $stable(fetch_addr))); // R4

    AST_POS_AT_FRAME: assert property (@(posedge clk) disable iff (rst)
        ((act_x != $past(act_x)) || (act_y != $past(act_y))) |->
        ($past(vblank) && !$past(vblank, 2))); // R10

    AST_BLANK_PASS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(hblank || vblank)) |-> (pix_rgb == $past(bg_rgb))); // R2

    AST_FULL_LEVELS: assert property (@(posedge clk) disable iff (rst)
        (pix_rgb != $past(bg_rgb)) |->
        ((pix_rgb[3*COL_W-1 -: COL_W] == '0 || pix_rgb[3*COL_W-1 -: COL_W] == '1) &&
         (pix_rgb[2*COL_W-1 -: COL_W] == '0 || pix_rgb[2*COL_W-1 -: COL_W] == '1) &&
         (pix_rgb[COL_W-1:0] == '0 || pix_rgb[COL_W-1:0] == '1))); // R7

endmodule

bind cursor_overlay cursor_overlay_chk #(.CNT_W(CNT_W), .COL_W(COL_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .hblank     (hblank),
    .vblank     (vblank),
    .bg_rgb     (bg_rgb),
    .pix_rgb    (pix_rgb),
    .fetch_req  (fetch_req),
    .fetch_ack  (fetch_ack),
    .fetch_addr (fetch_addr),
    .act_x      (act_x),
    .act_y      (act_y)
);

// File: tb/cursor_overlay_tb.sv
module cursor_overlay_tb;
    import cursor_pkg::*;

    localparam int CNT_W = 11;
    localparam int COL_W = 8;
    localparam int RGB_W = 3 * COL_W;
    localparam int H_TOT = 40;
    localparam int H_ACT = 32;
    localparam int V_TOT = 24;
    localparam int V_ACT = 20;

    logic                    clk;
    logic                    rst;
    logic                    pos_we;
    logic [CNT_W-1:0]        pos_x_in;
    logic [CNT_W-1:0]        pos_y_in;
    logic [CNT_W-1:0]        hcnt;
    logic [CNT_W-1:0]        vcnt;
    logic                    hblank;
    logic                    vblank;
    logic [RGB_W-1:0]        bg_rgb;
    logic                    fetch_req;
    logic [FETCH_ADDR_W-1:0] fetch_addr;
    logic                    fetch_ack;
    logic [WORD_BITS-1:0]    fetch_data;
    logic [RGB_W-1:0]        pix_rgb;

    cursor_overlay #(.CNT_W(CNT_W), .COL_W(COL_W), .V_TOTAL(V_TOT)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .pos_we     (pos_we),
        .pos_x_in   (pos_x_in),
        .pos_y_in   (pos_y_in),
        .hcnt       (hcnt),
        .vcnt       (vcnt),
        .hblank     (hblank),
        .vblank     (vblank),
        .bg_rgb     (bg_rgb),
        .fetch_req  (fetch_req),
        .fetch_addr (fetch_addr),
        .fetch_ack  (fetch_ack),
        .fetch_data (fetch_data),
        .pix_rgb    (pix_rgb)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [RGB_W-1:0] exp_q[$];
    int               tag_q[$];

    int m_px = 0, m_py = 0, m_ax = 0, m_ay = 0;
    int exp_base = 0, exp_cnt = 0, got_cnt = 0;
    bit line_armed = 0;

    int px_tab[6] = '{0, 5, 20, 28, 10, 31};
    int py_tab[6] = '{0, 3, 10, 12, 22, 0};

    function automatic string tag_name(int t);
        case (t)
            2:  return "R2";
            7:  return "R7 (R6 column pick)";
            8:  return "R8";
            9:  return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic logic [15:0] spr_word(int a);
        logic [15:0] w;
        w = 16'(a * 40503 + 7483);
        return w ^ 16'(a << 7);
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(int h, int v, bit we, int wx, int wy);
        logic [RGB_W-1:0] bg;
        logic [RGB_W-1:0] ev;
        int tag, dx, dy, nl, r;
        logic [15:0] w;
        logic [3:0] nib;
        @(negedge clk);
        if (v == V_ACT && h == 0) begin
            m_ax = m_px;
            m_ay = m_py;
        end
        bg = {8'(h * 5 + 3), 8'(v * 9 + 1), 8'(h ^ (v * 3))};
        hcnt     = CNT_W'(h);
        vcnt     = CNT_W'(v);
        hblank   = (h >= H_ACT);
        vblank   = (v >= V_ACT);
        bg_rgb   = bg;
        pos_we   = we;
        pos_x_in = CNT_W'(wx);
        pos_y_in = CNT_W'(wy);
        ev = bg;
        if (h >= H_ACT || v >= V_ACT) begin
            tag = 2;
        end else begin
            dx = h - m_ax;
            dy = v - m_ay;
            if (dx >= 0 && dx < 16 && dy >= 0 && dy < 16) begin
                w   = spr_word(dy * 4 + dx / 4);
                nib = 4'(w >> (12 - 4 * (dx % 4)));
                if (nib[3]) begin
                    ev  = {{8{nib[2]}}, {8{nib[1]}}, {8{nib[0]}}};
                    tag = 7;
                end else begin
                    tag = 8;
                end
            end else begin
                tag = 9;
            end
            if (m_px != m_ax || m_py != m_ay) tag = 10;
        end
        exp_q.push_back(ev);
        tag_q.push_back(tag);
        if (h == 0 && line_armed) begin
            check(got_cnt == exp_cnt, "R3 word count", got_cnt, exp_cnt);
        end
        if (h == H_ACT) begin
            nl = (v == V_TOT - 1) ? 0 : v + 1;
            r = nl - m_ay;
            exp_cnt  = (r >= 0 && r < 16) ? 4 : 0;
            exp_base = r * 4;
            got_cnt  = 0;
            line_armed = 1;
        end
        if (we) begin
            m_px = wx;
            m_py = wy;
        end
    endtask

    // Memory responder: acknowledges each request on the following edge.
    initial begin
        fetch_ack  = 1'b0;
        fetch_data = '0;
        forever begin
            @(negedge clk);
            if (!rst && fetch_req) begin
                check(int'(fetch_addr) == exp_base + got_cnt, "R4 address",
                      fetch_addr, exp_base + got_cnt);
                check(hblank || vblank, "R5 request in blanking", 0, 1);
                got_cnt++;
                fetch_ack  = 1'b1;
                fetch_data = spr_word(int'(fetch_addr));
            end else begin
                fetch_ack = 1'b0;
            end
        end
    end

    // Scoreboard monitor.
    initial begin
        logic [RGB_W-1:0] e;
        int t;
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(pix_rgb == e, tag_name(t), pix_rgb, e);
            end
        end
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        pos_we = 1'b0;
        pos_x_in = '0;
        pos_y_in = '0;
        hcnt = '0;
        vcnt = CNT_W'(V_ACT);
        hblank = 1'b0;
        vblank = 1'b1;
        bg_rgb = 24'h123456;
        repeat (4) @(negedge clk);
        check(pix_rgb == '0, "R1 pixel in reset", pix_rgb, 0);
        check(fetch_req == 1'b0, "R1 request in reset", fetch_req, 0);
        rst = 1'b0;
        for (int v = V_ACT; v < V_TOT; v++) begin
            for (int h = 0; h < H_TOT; h++) begin
                drive(h, v, (v == V_ACT + 1 && h == 5), px_tab[1], py_tab[1]);
            end
        end
        for (int f = 1; f <= 6; f++) begin
            for (int v = 0; v < V_TOT; v++) begin
                for (int h = 0; h < H_TOT; h++) begin
                    if (f < 5 && v == 5 && h == 10)
                        drive(h, v, 1'b1, px_tab[f + 1], py_tab[f + 1]);
                    else
                        drive(h, v, 1'b0, 0, 0);
                end
            end
        end
        drive(0, 0, 1'b0, 0, 0);
        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule